// File: doc/BRIEF.md
# Serial Sampling-Converter Readout Sequencer

This block runs a 16-bit sampling converter that has a serial output, using the mode in which the convert strobe also acts as the chip select. One start request from the user produces one full conversion. The block raises the convert strobe and holds it high for the worst-case conversion time. It then drops the strobe to enable the converter's serial output and waits until the first bit is valid. It captures that bit, which is the most significant one, and then produces fifteen serial-clock pulses to move the remaining bits out. The captured word is presented on a parallel output together with a one-cycle valid pulse.

Every analog timing limit is a parameter counted in system-clock cycles. These limits are the conversion time, the minimum strobe pulse width, the output-enable delay, the serial-clock high and low times, the acquisition time and the minimum spacing between conversions. After a read, the strobe is driven high again for a short pulse so that the serial output returns to high impedance. The strobe then rests low, which means the next start always produces a clean rising edge. The busy flag stays high until every spacing limit has been met, and start requests made while it is high have no effect.

Top module: `sar_adc_reader`

## Requirements
- R1: While reset is applied and while idle, the strobe (cnv_o), the serial clock (sck_o), busy_o and valid_o are all low.
- R2: A start_i sampled high while busy_o is low drives cnv_o and busy_o high on the next cycle. cnv_o then stays high for exactly CONV_CYC cycles.
- R3: After cnv_o falls, the block waits EN_CYC cycles and then captures the first serial bit. sck_o rises on that same clock edge.
- R4: sck_o produces exactly DW-1 pulses, each SCK_HI_CYC cycles high and then SCK_LO_CYC cycles low. sck_o is never high while cnv_o is high.
- R5: Every bit after the first is sampled on the edge one full serial-clock period (SCK_HI_CYC+SCK_LO_CYC cycles) after the falling edge that launched it. For the last bit, this sample point is reached with no further sck_o pulse.
- R6: result_o holds the serial bits in arrival order, with the first bit at position DW-1 and the last at position 0.
- R7: valid_o is high for exactly one cycle per accepted start. This happens CONV_CYC+EN_CYC+(DW-1)*(SCK_HI_CYC+SCK_LO_CYC)+SCK_HI_CYC cycles after acceptance. result_o does not change at any other time.
- R8: On the cycle valid_o is high, cnv_o goes high again. It stays high for CNVH_CYC cycles and then returns low.
- R9: busy_o falls at the latest of three points: CYCLE_MIN_CYC cycles after acceptance, ACQ_CYC cycles after valid_o, and the end of the strobe pulse from R8.
- R10: A start_i request while busy_o is high is ignored. It does not extend the timing or cause a further conversion.
- R11: sdo_i has no effect on result_o while cnv_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request, sampled on each rising clock edge |
| busy_o | output | 1 | High from acceptance until the next start can be taken |
| valid_o | output | 1 | One-cycle pulse marking a new result |
| result_o | output | DW | Most recent captured word |
| cnv_o | output | 1 | Convert strobe / chip select to the converter |
| sck_o | output | 1 | Serial clock to the converter |
| sdo_i | input | 1 | Serial data from the converter |

## Verification
The hardest condition to reach is a start request that lands exactly on the first cycle after busy_o falls. A single cycle of error in the spacing logic shifts the next conversion by one cycle, and a bench that waits generously never sees it. The stimulus therefore holds start_i high across several conversions so that each one is accepted at the earliest legal edge. It also sends a pulse timed to the falling edge of busy_o. The converter model launches each bit after a short delay following the serial clock's falling edge and drives toggling garbage while the strobe is high. Sampling at the wrong point, or while the strobe is high, therefore corrupts the captured words.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CONV  = 3'd1,
        ST_EN    = 3'd2,
        ST_SHIFT = 3'd3,
        ST_POST  = 3'd4
    } seq_state_e;

endpackage

// File: rtl/sar_rd_sck_gen.sv
module sar_rd_sck_gen #(
    parameter int NBITS = 16,
    parameter int HI    = 4,
    parameter int LO    = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic sck,
    output logic sample,
    output logic last
);
    localparam int PER = HI + LO;
    localparam int SW  = $clog2(NBITS + 1);
    localparam int PW  = $clog2(PER);
    localparam logic [PW-1:0] HI_LAST  = PW'(HI - 1);
    localparam logic [PW-1:0] PER_LAST = PW'(PER - 1);
    localparam logic [SW-1:0] SLOT_END = SW'(NBITS);
    localparam logic [SW-1:0] SLOT_PUL = SW'(NBITS - 1);

    typedef struct packed {
        logic          act;
        logic          sck;
        logic [SW-1:0] slot;
        logic [PW-1:0] ph;
    } gen_t;

    gen_t q, d;

    always_comb begin
        d      = q;
        sample = 1'b0;
        last   = 1'b0;
        if (go) begin
            d.act  = 1'b1;
            d.sck  = 1'b1;
            d.slot = SW'(1);
            d.ph   = '0;
        end else if (q.act) begin
            if (q.ph == HI_LAST) begin
                d.sck = 1'b0;
                if (q.slot >= SW'(2)) begin
                    sample = 1'b1;
                end
                if (q.slot == SLOT_END) begin
                    last  = 1'b1;
                    d.act = 1'b0;
                end
            end
            if (q.ph == PER_LAST) begin
                d.ph   = '0;
                d.slot = q.slot + 1'b1;
                d.sck  = (q.slot < SLOT_PUL);
            end else begin
                d.ph = q.ph + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sck = q.sck;

endmodule

// File: rtl/sar_rd_shifter.sv
module sar_rd_shifter #(
    parameter int NBITS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap,
    input  logic             sdo,
    output logic [NBITS-1:0] word_nx
);
    logic [NBITS-1:0] sh_q, sh_d;

    always_comb begin
        word_nx = {sh_q[NBITS-2:0], sdo};
        sh_d    = cap ? word_nx : sh_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

endmodule

// File: rtl/sar_rd_spacing.sv
module sar_rd_spacing #(
    parameter int CYC = 1250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic ok
);
    localparam int W = $clog2(CYC + 1);
    localparam logic [W-1:0] SAT  = W'(CYC);
    localparam logic [W-1:0] LAST = W'(CYC - 1);

    logic [W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (restart) begin
            cnt_d = '0;
        end else if (cnt_q < SAT) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= SAT;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign ok = (cnt_q >= LAST);

endmodule

// File: rtl/sar_adc_reader.sv
module sar_adc_reader
    import sar_rd_pkg::*;
#(
    parameter int DW            = 16,
    parameter int CONV_CYC      = 800,
    parameter int CNVH_CYC      = 3,
    parameter int EN_CYC        = 6,
    parameter int SCK_HI_CYC    = 4,
    parameter int SCK_LO_CYC    = 5,
    parameter int ACQ_CYC       = 450,
    parameter int CYCLE_MIN_CYC = 1250
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    output logic          busy_o,
    output logic          valid_o,
    output logic [DW-1:0] result_o,
    output logic          cnv_o,
    output logic          sck_o,
    input  logic          sdo_i
);
    localparam int T1   = (CONV_CYC > EN_CYC) ? CONV_CYC : EN_CYC;
    localparam int T2   = (ACQ_CYC > CNVH_CYC) ? ACQ_CYC : CNVH_CYC;
    localparam int TMAX = (T1 > T2) ? T1 : T2;
    localparam int CW   = $clog2(TMAX + 1);
    localparam logic [CW-1:0] CONV_LAST = CW'(CONV_CYC - 1);
    localparam logic [CW-1:0] EN_LAST   = CW'(EN_CYC - 1);
    localparam logic [CW-1:0] CNVH_LAST = CW'(CNVH_CYC - 1);
    localparam logic [CW-1:0] ACQ_LAST  = CW'(ACQ_CYC - 1);
    localparam logic [CW-1:0] CNT_SAT   = '1;

    typedef struct packed {
        seq_state_e    state;
        logic [CW-1:0] cnt;
        logic          cnv;
        logic          valid;
        logic [DW-1:0] result;
    } regs_t;

    regs_t q, d;

    logic          sck_go, sck_sample, sck_last, cap_msb, restart, space_ok;
    logic [DW-1:0] word_nx;

    sar_rd_sck_gen #(
        .NBITS(DW),
        .HI   (SCK_HI_CYC),
        .LO   (SCK_LO_CYC)
    ) u_sck (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (sck_go),
        .sck   (sck_o),
        .sample(sck_sample),
        .last  (sck_last)
    );

    sar_rd_shifter #(
        .NBITS(DW)
    ) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap    (cap_msb | sck_sample),
        .sdo    (sdo_i),
        .word_nx(word_nx)
    );

    sar_rd_spacing #(
        .CYC(CYCLE_MIN_CYC)
    ) u_space (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(restart),
        .ok     (space_ok)
    );

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        sck_go  = 1'b0;
        cap_msb = 1'b0;
        restart = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (start_i) begin
                    d.state = ST_CONV;
                    d.cnt   = '0;
                    d.cnv   = 1'b1;
                    restart = 1'b1;
                end
            end
            ST_CONV: begin
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == CONV_LAST) begin
                    d.cnv   = 1'b0;
                    d.cnt   = '0;
                    d.state = ST_EN;
                end
            end
            ST_EN: begin
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == EN_LAST) begin
                    sck_go  = 1'b1;
                    cap_msb = 1'b1;
                    d.state = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (sck_last) begin
                    d.valid  = 1'b1;
                    d.result = word_nx;
                    d.cnv    = 1'b1;
                    d.cnt    = '0;
                    d.state  = ST_POST;
                end
            end
            ST_POST: begin
                if (q.cnt != CNT_SAT) begin
                    d.cnt = q.cnt + 1'b1;
                end
                if (q.cnt == CNVH_LAST) begin
                    d.cnv = 1'b0;
                end
                if ((q.cnt >= ACQ_LAST) && (q.cnt >= CNVH_LAST) && space_ok) begin
                    d.cnv   = 1'b0;
                    d.state = ST_IDLE;
                end
            end
            default: begin
                d = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy_o   = (q.state != ST_IDLE);
    assign valid_o  = q.valid;
    assign result_o = q.result;
    assign cnv_o    = q.cnv;

endmodule

// File: rtl/sar_rd_checker.sv
module sar_rd_checker #(
    parameter int DW        = 16,
    parameter int CYCLE_MIN = 1250
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          busy_o,
    input logic          valid_o,
    input logic [DW-1:0] result_o,
    input logic          cnv_o,
    input logic          sck_o
);
    localparam int GW = $clog2(CYCLE_MIN + 2);
    localparam logic [GW-1:0] GSAT = GW'(CYCLE_MIN);

    logic          busy_p;
    logic [GW-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_p <= 1'b0;
            gap_q  <= GSAT;
        end else begin
            busy_p <= busy_o;
            if (busy_o && !busy_p) begin
                gap_q <= GW'(1);
            end else if (gap_q < GSAT) begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!sck_o && !cnv_o));

    assert_start_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && cnv_o));

    assert_sck_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_o |-> !sck_o);

    assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(result_o));

    assert_release_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (busy_o && cnv_o));

    assert_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !busy_p) |-> (gap_q >= GSAT));

endmodule

bind sar_adc_reader sar_rd_checker #(
    .DW       (DW),
    .CYCLE_MIN(CYCLE_MIN_CYC)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .busy_o  (busy_o),
    .valid_o (valid_o),
    .result_o(result_o),
    .cnv_o   (cnv_o),
    .sck_o   (sck_o)
);

// File: tb/sar_adc_reader_test.sv
module sar_adc_reader_test;
    localparam int DW    = 16;
    localparam int CONV  = 20;
    localparam int CNVH  = 3;
    localparam int EN    = 3;
    localparam int HI    = 2;
    localparam int LO    = 3;
    localparam int ACQ   = 10;
    localparam int CYC   = 115;
    localparam int P     = HI + LO;
    localparam int A     = CONV + EN;
    localparam int DONE  = A + (DW - 1) * P + HI;
    localparam int BA    = (CYC > DONE + ACQ) ? CYC : DONE + ACQ;
    localparam int BEND  = (BA > DONE + CNVH) ? BA : DONE + CNVH;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic sdo_i = 1'b0;
    logic busy_o, valid_o, cnv_o, sck_o;
    logic [DW-1:0] result_o;

    always #2 clk = ~clk;

    sar_adc_reader #(
        .DW(DW), .CONV_CYC(CONV), .CNVH_CYC(CNVH), .EN_CYC(EN),
        .SCK_HI_CYC(HI), .SCK_LO_CYC(LO), .ACQ_CYC(ACQ), .CYCLE_MIN_CYC(CYC)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
        .valid_o(valid_o), .result_o(result_o), .cnv_o(cnv_o),
        .sck_o(sck_o), .sdo_i(sdo_i)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit armed = 1'b0;
    bit done_run = 1'b0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] word_for(input int n);
        case (n)
            0: return 16'hFFFF;
            1: return 16'h0000;
            2: return 16'h8001;
            3: return 16'h7FFE;
            default: return DW'((n * 40503) ^ 16'h5A5A);
        endcase
    endfunction

    // reference model: time since acceptance drives every expected output
    bit busy_m = 1'b0;
    int t_m = 0;
    int n_acc = 0;
    int n_valid = 0;
    logic [DW-1:0] cur_word = '0;
    logic [DW-1:0] res_m = '0;
    bit exp_cnv, exp_sck, exp_valid;

    always @(posedge clk) begin
        if (!rst_n) begin
            busy_m = 0;
            t_m = 0;
        end else if (!busy_m) begin
            if (start_i) begin
                busy_m = 1;
                t_m = 0;
                cur_word = word_for(n_acc);
                n_acc++;
            end
        end else begin
            t_m++;
            if (t_m == BEND) busy_m = 0;
        end
        exp_cnv   = busy_m && ((t_m < CONV) || (t_m >= DONE && t_m < DONE + CNVH));
        exp_sck   = busy_m && (t_m >= A) && (t_m < A + (DW - 1) * P) && (((t_m - A) % P) < HI);
        exp_valid = busy_m && (t_m == DONE);
        if (exp_valid) res_m = cur_word;
    end

    // converter model: bits launched after a short delay, garbage while strobe high
    logic prev_cnv = 1'b0;
    logic prev_sck = 1'b0;
    logic target = 1'b0;
    logic junk = 1'b0;
    logic pipe0 = 1'b0;
    int idx = DW - 1;

    always @(negedge clk) begin
        if (cnv_o) begin
            junk = ~junk;
            target = junk;
            idx = DW - 1;
        end else if (prev_cnv) begin
            idx = DW - 1;
            target = cur_word[idx];
        end else if (prev_sck && !sck_o) begin
            if (idx > 0) idx--;
            target = cur_word[idx];
        end
        prev_cnv = cnv_o;
        prev_sck = sck_o;
        sdo_i <= pipe0;
        pipe0 <= target;
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (armed && rst_n && !done_run) begin
            check(cnv_o == exp_cnv, "R2/R8 cnv", cnv_o, exp_cnv);
            check(sck_o == exp_sck, "R3/R4/R5 sck", sck_o, exp_sck);
            check(busy_o == busy_m, "R9/R10 busy", busy_o, busy_m);
            check(valid_o == exp_valid, "R7 valid", valid_o, exp_valid);
            check(result_o == res_m, "R6/R11 result", result_o, res_m);
            if (valid_o) n_valid++;
        end
    end

    task automatic wait_idle();
        do @(negedge clk); while (busy_o);
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        check(!cnv_o && !sck_o && !busy_o && !valid_o, "R1 reset",
              {cnv_o, sck_o, busy_o, valid_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        armed = 1'b1;
        check(!cnv_o && !sck_o && !busy_o && !valid_o, "R1 idle",
              {cnv_o, sck_o, busy_o, valid_o}, 0);
        repeat (4) @(negedge clk);
        // single conversion
        pulse_start();
        wait_idle();
        repeat (3) @(negedge clk);
        // R10: pulses while busy are ignored
        pulse_start();
        repeat (5) @(negedge clk);
        pulse_start();
        repeat (40) @(negedge clk);
        pulse_start();
        repeat (50) @(negedge clk);
        pulse_start();
        wait_idle();
        repeat (2) @(negedge clk);
        // R9: start held high, each conversion taken at the earliest edge
        start_i = 1'b1;
        repeat (400) @(negedge clk);
        start_i = 1'b0;
        // wait for busy to fall, then request on the very next edge
        do @(negedge clk); while (!busy_o);
        wait_idle();
        pulse_start();
        wait_idle();
        repeat (5) @(negedge clk);
        done_run = 1'b1;
        check(n_acc == 7, "R10 accepted count", n_acc, 7);
        check(n_valid == n_acc, "R7 valid count", n_valid, n_acc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule